// File: doc/BRIEF.md
# Serial Peripheral Interface Controller with Flag Logic

The block moves bytes over a four-wire serial link and is controlled through four byte-wide registers on a simple read/write port. As a master it makes its own serial clock from the system clock. The divide ratio comes from a two-bit code and a double-speed bit. It shifts the outgoing byte out MSB first on one line and gathers the incoming byte from the other line. As a slave it follows a serial clock supplied from outside while its select input is held low. Both roles use clock mode 0: the line idles low, data is captured on the rising edge and shifted on the falling edge.

A completion flag tells software that a byte has finished. The same flag is raised when a master that watches its select pin sees that pin pulled low by another device. In that case the block also drops back to slave. The flag drives an interrupt request with a programmable two-bit level. It is cleared by an acknowledge pulse, or by reading the status register while the flag is set and then touching the data register. A collision flag records a data write made while a byte is still in flight.

The shift engine is a four-state machine. ST_IDLE goes to ST_MLOW on a data write in master role, or to ST_SLAVE when select goes low in slave role. ST_MLOW goes to ST_MHIGH after half a clock period, and ST_MHIGH goes back to ST_MLOW after the other half. ST_MHIGH goes to ST_IDLE after the eighth falling edge. Any state goes to ST_IDLE when the block is disabled, on a mode fault, or when the role or select no longer fits the current state.

Top module: `spi_port_ctl`

## Requirements
- R1: With the double-speed bit (control bit 7) at 0, divider codes 0, 1, 2 and 3 (control bits 1:0) give a master serial clock period of 4, 16, 64 and 128 system clocks.
- R2: With the double-speed bit at 1, divider codes 0, 1, 2 and 3 give a period of 2, 8, 32 and 64 system clocks.
- R3: A data write (address 3) in master role sends that byte MSB first while capturing the input line. After completion, a data read returns the captured byte.
- R4: The flag (status bit 7) becomes visible one system clock after the eighth falling serial clock edge. The request output is high exactly while the flag is set and the level (address 1, bits 1:0) is nonzero, and the level output then carries that level. Level 0 keeps the request low.
- R5: An acknowledge pulse clears the flag.
- R6: A status read (address 2) that finds the flag set, followed by a data access, clears both the flag and the collision flag. A data access with no such status read before it leaves the flag set.
- R7: A data write while a byte is in flight sets the collision flag (status bit 6), and the written value is discarded.
- R8: In master role with select monitoring on (control bit 5), enabled (bit 6), a low select input sets the flag, clears the master bit (bit 4) and stops the serial clock. With monitoring off, a low select has no effect.
- R9: In slave role, with select low, the block captures the input line on external clock rises and presents the preloaded byte MSB first. Its own serial clock output stays low whatever divider code is set.
- R10: After reset every register reads 0. Address 1 bits 7:2 and control bits 3:2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request |
| irq_level | output | 2 | Level of the active request |
| sck_o | output | 1 | Serial clock out (master) |
| mosi_o | output | 1 | Serial data out (master) |
| miso_i | input | 1 | Serial data in (master) |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_i | input | 1 | Serial data in (slave) |
| miso_o | output | 1 | Serial data out (slave) |
| ss_n_i | input | 1 | Select input, active low |

## Verification
The bench sweeps all eight divider settings and measures the period between serial clock rises. A swapped table or an ignored double-speed bit shows up as a wrong count. In loopback, a shift in the wrong direction or a missed last bit returns a corrupted byte. The bench watches the request output around the final falling edge, so a flag raised one edge early or one cycle late is caught. It also covers the two clear paths, including a data read with no status read before it: a design that clears on any data access loses the flag there. A write during a transfer, a monitored select pulled low, and slave shifting with the divider set to its slowest code each have their own checks. A design that takes the colliding byte, keeps the master role, or drives its own clock as a slave will fail them.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MLOW  = 2'd1,
        ST_MHIGH = 2'd2,
        ST_SLAVE = 2'd3
    } spi_state_e;

    localparam logic [1:0] ADR_CTRL   = 2'd0;
    localparam logic [1:0] ADR_INTLV  = 2'd1;
    localparam logic [1:0] ADR_STATUS = 2'd2;
    localparam logic [1:0] ADR_DATA   = 2'd3;

    localparam logic [7:0] CTRL_MASK = 8'hF3;
    localparam int CTRL_FAST   = 7;
    localparam int CTRL_EN     = 6;
    localparam int CTRL_SSMON  = 5;
    localparam int CTRL_MASTER = 4;

    // Half of the serial clock period, in system clocks.
    function automatic int unsigned half_cycles(input logic [1:0] code, input logic fast);
        int unsigned lg;
        unique case (code)
            2'd0:    lg = 2;
            2'd1:    lg = 4;
            2'd2:    lg = 6;
            default: lg = 7;
        endcase
        if (fast) lg = lg - 1;
        return 32'd1 << (lg - 1);
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= RST_VAL;
            else        pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_port_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          master,
    input  logic          ss_mon,
    input  logic          fast,
    input  logic [1:0]    div_code,
    input  logic          load,
    input  logic [DW-1:0] load_byte,
    input  logic          miso_i,
    input  logic          sck_s,
    input  logic          mosi_s,
    input  logic          ss_low_s,
    output logic          sck_o,
    output logic          mosi_o,
    output logic          miso_o,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rx_byte,
    output logic          fault
);
    localparam int HCW = 7;
    localparam int BW  = (DW > 1) ? $clog2(DW) : 1;

    spi_state_e     state_q, state_d;
    logic [HCW-1:0] half_q;
    logic [BW-1:0]  bit_q;
    logic [DW-1:0]  sh_q;
    logic           in_bit_q;
    logic           sck_q;
    logic           sck_prev_q;
    logic           slv_act_q;
    logic           done_q;
    logic [DW-1:0]  rx_q;

    logic           half_hit, last_bit, sck_rise, sck_fall;

    assign half_hit = (half_q == HCW'(half_cycles(div_code, fast) - 1));
    assign last_bit = (bit_q == BW'(DW - 1));
    assign sck_rise = sck_s && !sck_prev_q;
    assign sck_fall = !sck_s && sck_prev_q;
    assign fault    = enable && master && ss_mon && ss_low_s;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable && !fault) begin
                    if (master && load)         state_d = ST_MLOW;
                    else if (!master && ss_low_s) state_d = ST_SLAVE;
                end
            end
            ST_MLOW: begin
                if (!enable || !master || fault) state_d = ST_IDLE;
                else if (half_hit)               state_d = ST_MHIGH;
            end
            ST_MHIGH: begin
                if (!enable || !master || fault) state_d = ST_IDLE;
                else if (half_hit)               state_d = last_bit ? ST_IDLE : ST_MLOW;
            end
            ST_SLAVE: begin
                if (!enable || master || !ss_low_s) state_d = ST_IDLE;
            end
        endcase
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q     <= '0;
            bit_q      <= '0;
            sh_q       <= '0;
            in_bit_q   <= 1'b0;
            sck_q      <= 1'b0;
            sck_prev_q <= 1'b0;
            slv_act_q  <= 1'b0;
            done_q     <= 1'b0;
            rx_q       <= '0;
        end else begin
            done_q     <= 1'b0;
            sck_prev_q <= sck_s;
            sck_q      <= (state_d == ST_MHIGH);
            if (load) sh_q <= load_byte;
            unique case (state_q)
                ST_IDLE: begin
                    half_q    <= '0;
                    bit_q     <= '0;
                    slv_act_q <= 1'b0;
                end
                ST_MLOW: begin
                    half_q <= half_hit ? '0 : half_q + 1'b1;
                    if (half_hit) in_bit_q <= miso_i;
                end
                ST_MHIGH: begin
                    half_q <= half_hit ? '0 : half_q + 1'b1;
                    if (half_hit) begin
                        sh_q <= {sh_q[DW-2:0], in_bit_q};
                        if (last_bit) begin
                            done_q <= 1'b1;
                            rx_q   <= {sh_q[DW-2:0], in_bit_q};
                            bit_q  <= '0;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                ST_SLAVE: begin
                    if (sck_rise) begin
                        in_bit_q  <= mosi_s;
                        slv_act_q <= 1'b1;
                    end else if (sck_fall && slv_act_q) begin
                        sh_q <= {sh_q[DW-2:0], in_bit_q};
                        if (last_bit) begin
                            done_q    <= 1'b1;
                            rx_q      <= {sh_q[DW-2:0], in_bit_q};
                            bit_q     <= '0;
                            slv_act_q <= 1'b0;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign sck_o   = sck_q;
    assign mosi_o  = sh_q[DW-1];
    assign miso_o  = sh_q[DW-1];
    assign busy    = (state_q == ST_MLOW) || (state_q == ST_MHIGH) || slv_act_q;
    assign done    = done_q;
    assign rx_byte = rx_q;
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
    import spi_port_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    input  logic          irq_ack,
    output logic          irq,
    output logic [1:0]    irq_level,
    input  logic          busy,
    input  logic          done,
    input  logic [DW-1:0] rx_byte,
    input  logic          fault,
    output logic          enable,
    output logic          master,
    output logic          ss_mon,
    output logic          fast,
    output logic [1:0]    div_code,
    output logic          load,
    output logic [DW-1:0] load_byte,
    output logic          wcol
);
    logic [7:0]    ctrl_q;
    logic [1:0]    level_q;
    logic          flag_q, wcol_q, armed_q;
    logic [DW-1:0] rx_q;
    logic          data_wr, data_acc, stat_rd, seq_clr;

    assign data_wr  = wr_en && (addr == ADR_DATA);
    assign data_acc = (wr_en || rd_en) && (addr == ADR_DATA);
    assign stat_rd  = rd_en && (addr == ADR_STATUS);
    assign seq_clr  = data_acc && armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            level_q <= '0;
            flag_q  <= 1'b0;
            wcol_q  <= 1'b0;
            armed_q <= 1'b0;
            rx_q    <= '0;
        end else begin
            if (wr_en && addr == ADR_CTRL)  ctrl_q  <= wdata & CTRL_MASK;
            if (fault)                      ctrl_q[CTRL_MASTER] <= 1'b0;
            if (wr_en && addr == ADR_INTLV) level_q <= wdata[1:0];
            if (done) rx_q <= rx_byte;

            if (stat_rd && flag_q) armed_q <= 1'b1;
            else if (data_acc)     armed_q <= 1'b0;

            if (done || fault)            flag_q <= 1'b1;
            else if (seq_clr || irq_ack)  flag_q <= 1'b0;

            if (data_wr && busy) wcol_q <= 1'b1;
            else if (seq_clr)    wcol_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr)
            ADR_CTRL:   rdata = ctrl_q;
            ADR_INTLV:  rdata = {6'b0, level_q};
            ADR_STATUS: rdata = {flag_q, wcol_q, 6'b0};
            ADR_DATA:   rdata = 8'(rx_q);
        endcase
    end

    assign enable    = ctrl_q[CTRL_EN];
    assign master    = ctrl_q[CTRL_MASTER];
    assign ss_mon    = ctrl_q[CTRL_SSMON];
    assign fast      = ctrl_q[CTRL_FAST];
    assign div_code  = ctrl_q[1:0];
    assign load      = data_wr && !busy;
    assign load_byte = DW'(wdata);
    assign wcol      = wcol_q;
    assign irq       = flag_q && (level_q != 2'd0);
    assign irq_level = irq ? level_q : 2'd0;
endmodule

// File: rtl/spi_port_ctl.sv
module spi_port_ctl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       irq_ack,
    output logic       irq,
    output logic [1:0] irq_level,
    output logic       sck_o,
    output logic       mosi_o,
    input  logic       miso_i,
    input  logic       sck_i,
    input  logic       mosi_i,
    output logic       miso_o,
    input  logic       ss_n_i
);
    localparam int DW = 8;

    logic          ctl_enable, ctl_master, ctl_ssmon, ctl_fast;
    logic [1:0]    ctl_div;
    logic          eng_load, eng_busy, eng_done, eng_fault, st_wcol;
    logic [DW-1:0] eng_load_byte, eng_rx;
    logic [2:0]    pins_s;

    spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n_i, mosi_i, sck_i}),
        .q     (pins_s)
    );

    spi_reg_file #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq_ack   (irq_ack),
        .irq       (irq),
        .irq_level (irq_level),
        .busy      (eng_busy),
        .done      (eng_done),
        .rx_byte   (eng_rx),
        .fault     (eng_fault),
        .enable    (ctl_enable),
        .master    (ctl_master),
        .ss_mon    (ctl_ssmon),
        .fast      (ctl_fast),
        .div_code  (ctl_div),
        .load      (eng_load),
        .load_byte (eng_load_byte),
        .wcol      (st_wcol)
    );

    spi_shift_engine #(.DW(DW)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (ctl_enable),
        .master    (ctl_master),
        .ss_mon    (ctl_ssmon),
        .fast      (ctl_fast),
        .div_code  (ctl_div),
        .load      (eng_load),
        .load_byte (eng_load_byte),
        .miso_i    (miso_i),
        .sck_s     (pins_s[0]),
        .mosi_s    (pins_s[1]),
        .ss_low_s  (!pins_s[2]),
        .sck_o     (sck_o),
        .mosi_o    (mosi_o),
        .miso_o    (miso_o),
        .busy      (eng_busy),
        .done      (eng_done),
        .rx_byte   (eng_rx),
        .fault     (eng_fault)
    );
endmodule

// File: rtl/spi_port_ctl_chk.sv
module spi_port_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic [1:0] irq_level,
    input logic       sck_o,
    input logic       busy,
    input logic       fault,
    input logic       master,
    input logic       wcol
);
    // R4: an active request always carries a nonzero level
    assert_irq_has_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_level != 2'd0));

    // R8: a mode fault demotes the block to slave on the next cycle
    assert_fault_demotes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !master);

    // R9: without the master role the serial clock output is held low
    assert_slave_sck_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !master |=> !sck_o);

    // R7: a collision is only recorded while a byte was in flight
    assert_wcol_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcol) |-> $past(busy));

    // R1: the serial clock only toggles during a transfer
    assert_sck_only_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> busy);
endmodule

bind spi_port_ctl spi_port_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .irq_level (irq_level),
    .sck_o     (sck_o),
    .busy      (eng_busy),
    .fault     (eng_fault),
    .master    (ctl_master),
    .wcol      (st_wcol)
);

// File: tb/spi_port_ctl_tb.sv
module spi_port_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0, irq_ack = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    logic [1:0] irq_level;
    logic       sck_o, mosi_o, miso_o;
    logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
    int         errs = 0, checks = 0;

    always #2 clk = ~clk;

    spi_port_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq_ack(irq_ack), .irq(irq),
        .irq_level(irq_level), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(mosi_o),
        .sck_i(sck_i), .mosi_i(mosi_i), .miso_o(miso_o), .ss_n_i(ss_n_i)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic master_xfer(input logic [1:0] code, input logic dbl, input logic [7:0] b);
        int rises = 0, falls = 0, t = 0, t1 = 0, t2 = 0, expn;
        logic prev = 1'b0;
        logic [7:0] r;
        string rq;
        rq   = dbl ? "R2" : "R1";
        expn = ((code < 3) ? (4 << (2 * code)) : 128) >> dbl;
        wr(2'd0, {dbl, 1'b1, 1'b0, 1'b1, 2'b00, code});
        wr(2'd3, b);
        while (falls < 8 && t < 4000) begin
            @(negedge clk); t++;
            if (sck_o && !prev) begin
                rises++;
                if (rises == 1) t1 = t;
                if (rises == 2) t2 = t;
            end
            if (!sck_o && prev) begin
                falls++;
                if (falls == 8) chk("R4", "flag not before final edge", int'(irq), 0);
            end
            prev = sck_o;
        end
        @(negedge clk);
        chk("R4", "flag one cycle after final edge", int'(irq), 1);
        chk("R4", "request level", int'(irq_level), 2);
        chk(rq, "sck period", t2 - t1, expn);
        rd(2'd2, r); chk("R4", "status flag", int'(r), 8'h80);
        rd(2'd3, r); chk("R3", "loopback byte", int'(r), int'(b));
        rd(2'd2, r); chk("R6", "status cleared by sequence", int'(r), 0);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [7:0] r, got;
        bit sck_seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset values and reserved bits
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r); chk("R10", "reset read", int'(r), 0);
        end
        chk("R10", "reset irq", int'(irq), 0);
        chk("R10", "reset sck", int'(sck_o), 0);
        wr(2'd1, 8'hFF); rd(2'd1, r); chk("R10", "level reserved bits", int'(r), 3);
        wr(2'd0, 8'hFF); rd(2'd0, r); chk("R10", "ctrl reserved bits", int'(r), 8'hF3);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h02);

        // R1, R2, R3: sweep all eight divider settings
        for (int i = 0; i < 8; i++)
            master_xfer(2'(i % 4), 1'(i / 4), 8'(8'hA5 ^ (i * 37)));

        // R4, R5: level 0 gates the request, acknowledge clears the flag
        wr(2'd0, 8'hD0);
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h3E);
        repeat (40) @(negedge clk);
        chk("R4", "level 0 keeps irq low", int'(irq), 0);
        chk("R4", "level 0 output", int'(irq_level), 0);
        wr(2'd1, 8'h03);
        chk("R4", "irq follows level", int'(irq), 1);
        chk("R4", "irq level 3", int'(irq_level), 3);
        ack();
        chk("R5", "irq after ack", int'(irq), 0);
        rd(2'd2, r); chk("R5", "status after ack", int'(r), 0);
        wr(2'd1, 8'h02);

        // R6: data access without prior status read keeps the flag
        wr(2'd3, 8'h11);
        repeat (40) @(negedge clk);
        rd(2'd3, r); chk("R3", "byte 11", int'(r), 8'h11);
        rd(2'd2, r); chk("R6", "flag kept without status read", int'(r), 8'h80);
        rd(2'd3, r);
        rd(2'd2, r); chk("R6", "flag cleared after sequence", int'(r), 0);

        // R7: write collision
        wr(2'd3, 8'h5A);
        wr(2'd3, 8'hFF);
        repeat (40) @(negedge clk);
        rd(2'd2, r); chk("R7", "flag and collision", int'(r), 8'hC0);
        rd(2'd3, r); chk("R7", "colliding write discarded", int'(r), 8'h5A);
        rd(2'd2, r); chk("R6", "both flags cleared", int'(r), 0);

        // R8: mode fault
        wr(2'd0, 8'h70);
        ss_n_i = 1'b0;
        repeat (5) @(negedge clk);
        rd(2'd0, r); chk("R8", "master bit cleared", int'(r), 8'h60);
        chk("R8", "fault sets flag", int'(irq), 1);
        chk("R8", "sck stopped", int'(sck_o), 0);
        ss_n_i = 1'b1;
        ack();
        wr(2'd0, 8'h50);
        ss_n_i = 1'b0;
        repeat (5) @(negedge clk);
        rd(2'd0, r); chk("R8", "unmonitored select ignored", int'(r), 8'h50);
        chk("R8", "no flag when unmonitored", int'(irq), 0);
        ss_n_i = 1'b1;
        repeat (3) @(negedge clk);

        // R9: slave transfer, divider set to slowest code and ignored
        wr(2'd0, 8'hC3);
        wr(2'd3, 8'h3C);
        ss_n_i = 1'b0;
        got = '0; sck_seen = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin
            mosi_i = 1'(8'hC6 >> i);
            for (int k = 0; k < 8; k++) begin @(negedge clk); if (sck_o) sck_seen = 1'b1; end
            got = {got[6:0], miso_o};
            sck_i = 1'b1;
            for (int k = 0; k < 8; k++) begin @(negedge clk); if (sck_o) sck_seen = 1'b1; end
            sck_i = 1'b0;
        end
        repeat (6) @(negedge clk);
        chk("R9", "slave flag", int'(irq), 1);
        chk("R9", "slave output byte", int'(got), 8'h3C);
        chk("R9", "slave sck_o low", int'(sck_seen), 0);
        rd(2'd2, r); chk("R9", "slave status", int'(r), 8'h80);
        rd(2'd3, r); chk("R9", "slave received byte", int'(r), 8'hC6);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule